// File: doc/BRIEF.md
# Bucket Occupancy Accumulator

This block builds a running occupancy histogram indexed by bunch-crossing position. Each accepted input record describes one bucket: a two-bit status code for every channel and a marker flag that says the record opens a new orbit. The block counts, per record, how many channels passed threshold A, how many passed threshold B and how many are dead. It adds those three counts into saturating accumulators held in on-chip RAM at the address of the record's bucket.

A bucket counter, forced to zero by the orbit marker, supplies the address. After a programmable number of completed orbits the block switches accumulation to a second bank. A readout stream then walks the finished bank in bucket order, presents each bucket's three totals for packet building and clears each entry once it is taken. The read-modify-write into RAM is pipelined, and a bucket that is hit by two records in a row gets the in-flight sum forwarded.

Input stream rule: a record is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during the RAM clear that follows reset and stays high afterwards. Output stream rule: an item moves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low the item is held unchanged. Stalling the output does not stall the input. It only defers the next bank switch.

Top module: `occ_accum`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is low for exactly NB clock cycles while both banks are cleared. After that `in_ready` is high and stays high.
- R2: Channel i's code sits at `in_codes[2i+1:2i]`. A code with bit 1 set (10 or 11) counts toward threshold A. A code with bit 0 set (01 or 11) counts toward threshold B. Code 00 is a dead channel: it counts toward neither threshold and only toward the dead total.
- R3: An accepted record with `in_bc0` high belongs to bucket 0. Any other accepted record belongs to the previous accepted record's bucket plus one, wrapping from NB-1 to 0. Cycles with no accepted record do not advance the bucket.
- R4: Each bucket entry of the active bank holds the sum of the A, B and dead counts of every record accepted for that bucket since the bank was last cleared.
- R5: Each accumulator saturates at 2^ACC_W-1 instead of wrapping.
- R6: Records that hit the same bucket on consecutive cycles (repeated `in_bc0`) are all added. None is lost.
- R7: A period ends on the accepted record for bucket NB-1 that completes the `orbits_per_period`-th orbit (a value of 0 acts as 1). That record still goes into the current bank, and later records go into the other bank.
- R8: After a bank switch the output stream delivers NB items for buckets 0, 1, …, NB-1 of the finished bank, in that order. The bucket number is on `out_bucket` and the totals are on `out_cnt_a`, `out_cnt_b` and `out_cnt_dead`. Each entry reads zero in its next period.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all output fields hold. `out_valid` falls only after a transfer.
- R10: If readout of the previous bank is still in progress when a period would end, the switch is deferred to the first later bucket NB-1 record at which readout is idle. Accumulation continues in the same bank until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbits_per_period | input | OPP_W | Orbits per integration period (0 acts as 1) |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted when high |
| in_bc0 | input | 1 | Record opens a new orbit (bucket 0) |
| in_codes | input | 2*NCH | Two-bit status code per channel |
| out_valid | output | 1 | Readout item valid |
| out_ready | input | 1 | Readout consumer ready |
| out_bucket | output | $clog2(NB) | Bucket number of the readout item |
| out_cnt_a | output | ACC_W | Threshold-A total |
| out_cnt_b | output | ACC_W | Threshold-B total |
| out_cnt_dead | output | ACC_W | Dead-channel total |

## Verification
On every cycle the assertions check the readout handshake: fields hold under stall, `out_valid` drops only after a transfer, and consecutive items step through the buckets in order. They also check that `in_ready` never drops once the clear has finished and that no readout appears before it. The totals themselves can only be shown by the bench's scenarios, which replay the code classification, bucket positioning, saturation, back-to-back forwarding and deferred bank switches in a reference model and compare every drained item.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {DR_IDLE, DR_READ, DR_SHOW} drain_st_t;
endpackage

// File: rtl/occ_classify.sv
module occ_classify #(
  parameter int NCH = 48,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic [2*NCH-1:0] codes,
  output logic [CW-1:0]    cnt_a,
  output logic [CW-1:0]    cnt_b,
  output logic [CW-1:0]    cnt_dead
);
  logic [NCH-1:0] hit_a, hit_b, hit_d;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign hit_a[g] = codes[2*g+1];
      assign hit_b[g] = codes[2*g];
      assign hit_d[g] = (codes[2*g+1 -: 2] == 2'b00);
    end
  endgenerate

  always_comb begin
    cnt_a = '0;
    cnt_b = '0;
    cnt_dead = '0;
    for (int i = 0; i < NCH; i++) begin
      cnt_a    = cnt_a    + CW'(hit_a[i]);
      cnt_b    = cnt_b    + CW'(hit_b[i]);
      cnt_dead = cnt_dead + CW'(hit_d[i]);
    end
  end
endmodule

// File: rtl/occ_bank_ram.sv
module occ_bank_ram #(
  parameter int DEPTH = 7128,
  parameter int W     = 96,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_raddr,
  output logic [W-1:0]  a_rdata,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [W-1:0]  a_wdata,
  input  logic [AW-1:0] b_raddr,
  output logic [W-1:0]  b_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [W-1:0]  b_wdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_raddr];
    b_rdata <= mem[b_raddr];
    if (a_we) mem[a_waddr] <= a_wdata;
    if (b_we) mem[b_waddr] <= b_wdata;
  end
endmodule

// File: rtl/occ_drain.sv
module occ_drain import occ_pkg::*; #(
  parameter int NB = 3564,
  localparam int BKW = $clog2(NB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_bank,
  output logic           busy,
  output logic           cur_bank,
  output logic [BKW-1:0] cur_idx,
  output logic           clr_we,
  output logic           out_valid,
  input  logic           out_ready
);
  drain_st_t st;

  assign busy      = (st != DR_IDLE);
  assign out_valid = (st == DR_SHOW);
  assign clr_we    = (st == DR_SHOW) && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DR_IDLE;
      cur_bank <= 1'b0;
      cur_idx  <= '0;
    end else begin
      unique case (st)
        DR_IDLE: if (start) begin
          cur_bank <= start_bank;
          cur_idx  <= '0;
          st       <= DR_READ;
        end
        DR_READ: st <= DR_SHOW;
        DR_SHOW: if (out_ready) begin
          if (cur_idx == BKW'(NB - 1)) st <= DR_IDLE;
          else begin
            cur_idx <= cur_idx + 1'b1;
            st      <= DR_READ;
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/occ_accum.sv
module occ_accum import occ_pkg::*; #(
  parameter int NCH   = 48,
  parameter int NB    = 3564,
  parameter int ACC_W = 32,
  parameter int OPP_W = 16,
  localparam int BKW  = $clog2(NB),
  localparam int AW   = $clog2(2 * NB),
  localparam int CW   = $clog2(NCH + 1),
  localparam int WW   = 3 * ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPP_W-1:0] orbits_per_period,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bc0,
  input  logic [2*NCH-1:0] in_codes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BKW-1:0]   out_bucket,
  output logic [ACC_W-1:0] out_cnt_a,
  output logic [ACC_W-1:0] out_cnt_b,
  output logic [ACC_W-1:0] out_cnt_dead
);
  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a, input logic [CW-1:0] c);
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W+1)'(c);
    return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
  endfunction

  function automatic logic [AW-1:0] bank_addr(input logic bank, input logic [BKW-1:0] idx);
    return bank ? AW'(NB) + AW'(idx) : AW'(idx);
  endfunction

  // clear sweep after reset
  logic           init_busy;
  logic [BKW-1:0] init_idx;
  assign in_ready = !init_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
    end else if (init_busy) begin
      init_idx <= init_idx + 1'b1;
      if (init_idx == BKW'(NB - 1)) init_busy <= 1'b0;
    end
  end

  // stage 0: classify and position
  logic           take;
  logic [BKW-1:0] nxt_bkt, cur_bkt;
  logic [CW-1:0]  ca, cb, cd;
  logic           active;
  logic [AW-1:0]  s0_addr;

  assign take    = in_valid && in_ready;
  assign cur_bkt = in_bc0 ? '0 : nxt_bkt;
  assign s0_addr = bank_addr(active, cur_bkt);

  occ_classify #(.NCH(NCH)) u_cls (
    .codes(in_codes), .cnt_a(ca), .cnt_b(cb), .cnt_dead(cd)
  );

  // period control
  logic             orbit_end, period_due, swap, drn_busy;
  logic [OPP_W-1:0] orb_cnt, opp_last;

  assign opp_last   = (orbits_per_period == '0) ? '0 : orbits_per_period - 1'b1;
  assign orbit_end  = take && (cur_bkt == BKW'(NB - 1));
  assign period_due = orbit_end && (orb_cnt >= opp_last);
  assign swap       = period_due && !drn_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_bkt <= '0;
      orb_cnt <= '0;
      active  <= 1'b0;
    end else begin
      if (take) nxt_bkt <= (cur_bkt == BKW'(NB - 1)) ? '0 : cur_bkt + 1'b1;
      if (swap) begin
        active  <= ~active;
        orb_cnt <= '0;
      end else if (orbit_end && !period_due) begin
        orb_cnt <= orb_cnt + 1'b1;
      end
    end
  end

  // stage 1: add and write back, with one-deep forwarding
  logic          s1_v, fwd_hit;
  logic [AW-1:0] s1_addr;
  logic [CW-1:0] s1_ca, s1_cb, s1_cd;
  logic [WW-1:0] a_rdata, base, s1_sum, fwd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      fwd_hit <= 1'b0;
    end else begin
      s1_v    <= take;
      fwd_hit <= take && s1_v && (s1_addr == s0_addr);
    end
  end

  always_ff @(posedge clk) begin
    s1_addr  <= s0_addr;
    s1_ca    <= ca;
    s1_cb    <= cb;
    s1_cd    <= cd;
    fwd_word <= s1_sum;
  end

  assign base   = fwd_hit ? fwd_word : a_rdata;
  assign s1_sum = {sat_add(base[3*ACC_W-1:2*ACC_W], s1_cd),
                   sat_add(base[2*ACC_W-1:ACC_W],   s1_cb),
                   sat_add(base[ACC_W-1:0],         s1_ca)};

  // readout
  logic           drn_bank, drn_clr;
  logic [BKW-1:0] drn_idx;
  logic [WW-1:0]  b_rdata;

  occ_drain #(.NB(NB)) u_drn (
    .clk(clk), .rst_n(rst_n), .start(swap), .start_bank(active),
    .busy(drn_busy), .cur_bank(drn_bank), .cur_idx(drn_idx),
    .clr_we(drn_clr), .out_valid(out_valid), .out_ready(out_ready)
  );

  occ_bank_ram #(.DEPTH(2 * NB), .W(WW)) u_ram (
    .clk(clk),
    .a_raddr(s0_addr), .a_rdata(a_rdata),
    .a_we(init_busy || s1_v),
    .a_waddr(init_busy ? bank_addr(1'b0, init_idx) : s1_addr),
    .a_wdata(init_busy ? '0 : s1_sum),
    .b_raddr(bank_addr(drn_bank, drn_idx)), .b_rdata(b_rdata),
    .b_we(init_busy || drn_clr),
    .b_waddr(init_busy ? bank_addr(1'b1, init_idx) : bank_addr(drn_bank, drn_idx)),
    .b_wdata('0)
  );

  assign out_bucket   = drn_idx;
  assign out_cnt_a    = b_rdata[ACC_W-1:0];
  assign out_cnt_b    = b_rdata[2*ACC_W-1:ACC_W];
  assign out_cnt_dead = b_rdata[3*ACC_W-1:2*ACC_W];
endmodule

// File: rtl/occ_accum_chk.sv
module occ_accum_chk #(
  parameter int NB    = 3564,
  parameter int ACC_W = 32,
  localparam int BKW  = $clog2(NB)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BKW-1:0]   out_bucket,
  input logic [ACC_W-1:0] out_cnt_a,
  input logic [ACC_W-1:0] out_cnt_b,
  input logic [ACC_W-1:0] out_cnt_dead
);
  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bucket) && $stable(out_cnt_a)
                                   && $stable(out_cnt_b) && $stable(out_cnt_dead)));

  p_valid_drops_after_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  p_ready_stays_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  p_no_readout_in_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_bucket_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_bucket != BKW'(NB - 1))
      |=> ##1 (out_valid && out_bucket == BKW'($past(out_bucket, 2) + 1'b1)));
endmodule

bind occ_accum occ_accum_chk #(.NB(NB), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bucket(out_bucket), .out_cnt_a(out_cnt_a),
  .out_cnt_b(out_cnt_b), .out_cnt_dead(out_cnt_dead)
);

// File: tb/tb_occ_accum.sv
module tb_occ_accum;
  localparam int NCH = 48, NB = 4, ACC_W = 8, OPP_W = 16;
  localparam int BKW = $clog2(NB);
  localparam int MAXV = (1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [OPP_W-1:0] orbits_per_period = 16'd2;
  logic in_valid = 1'b0, in_bc0 = 1'b0, out_ready = 1'b0;
  logic [2*NCH-1:0] in_codes = '0;
  logic in_ready, out_valid;
  logic [BKW-1:0] out_bucket;
  logic [ACC_W-1:0] out_cnt_a, out_cnt_b, out_cnt_dead;

  always #2.5 clk = ~clk;

  occ_accum #(.NCH(NCH), .NB(NB), .ACC_W(ACC_W), .OPP_W(OPP_W)) dut (.*);

  typedef struct { int bkt; int a; int b; int d; } item_t;
  item_t q[$];
  int ma[2][NB], mb[2][NB], md[2][NB];
  int m_active = 0, m_orb = 0, m_nxt = 0;
  int n_tests = 0, n_fail = 0;
  string cur_req = "R4";
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  // driver side: model one accepted record, push expected readout on a switch
  task automatic model_rec(input bit bc0, input logic [2*NCH-1:0] codes, input bit idle);
    int cur, k, na, nb, nd, last;
    na = 0; nb = 0; nd = 0;
    for (int i = 0; i < NCH; i++) begin
      if (codes[2*i+1]) na++;
      if (codes[2*i]) nb++;
      if (codes[2*i+:2] == 2'b00) nd++;
    end
    cur = bc0 ? 0 : m_nxt;
    k = m_active;
    ma[k][cur] = sat(ma[k][cur] + na);
    mb[k][cur] = sat(mb[k][cur] + nb);
    md[k][cur] = sat(md[k][cur] + nd);
    m_nxt = (cur == NB - 1) ? 0 : cur + 1;
    if (cur == NB - 1) begin
      last = (orbits_per_period == 0) ? 0 : int'(orbits_per_period) - 1;
      if (m_orb >= last) begin
        if (idle) begin
          for (int j = 0; j < NB; j++) begin
            q.push_back('{j, ma[k][j], mb[k][j], md[k][j]});
            ma[k][j] = 0; mb[k][j] = 0; md[k][j] = 0;
          end
          m_active ^= 1;
          m_orb = 0;
        end
      end else m_orb++;
    end
  endtask

  // monitor side: pop and compare an item that transfers at the coming edge
  task automatic monitor();
    item_t e;
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", $sformatf("unexpected item bucket=%0d expected none", out_bucket));
      end else begin
        e = q.pop_front();
        chk(out_bucket == BKW'(e.bkt) && out_cnt_a == ACC_W'(e.a) &&
            out_cnt_b == ACC_W'(e.b) && out_cnt_dead == ACC_W'(e.d), cur_req,
            $sformatf("R8 item actual b=%0d a=%0d b=%0d d=%0d expected b=%0d a=%0d b=%0d d=%0d",
                      out_bucket, out_cnt_a, out_cnt_b, out_cnt_dead, e.bkt, e.a, e.b, e.d));
      end
    end
  endtask

  task automatic step(input bit v, input bit bc0, input logic [2*NCH-1:0] codes, input bit rdy);
    bit idle;
    idle = (q.size() == 0);
    in_valid = v; in_bc0 = bc0; in_codes = codes; out_ready = rdy;
    monitor();
    if (v && in_ready) model_rec(bc0, codes, idle);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2*NCH-1:0] rnd_codes();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic run_orbits(input int n, input int gap_pct, input int rdy_pct);
    for (int o = 0; o < n; o++) begin
      for (int b = 0; b < NB; b++) begin
        while (($urandom % 100) < gap_pct) step(1'b0, 1'b0, rnd_codes(), ($urandom % 100) < rdy_pct);
        step(1'b1, b == 0, rnd_codes(), ($urandom % 100) < rdy_pct);
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 200 && q.size() != 0; i++) step(1'b0, 1'b0, '0, 1'b1);
    chk(q.size() == 0 && !out_valid, "R8",
        $sformatf("drain end actual pending=%0d valid=%0b expected 0/0", q.size(), out_valid));
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and clear sweep
    chk(!in_ready && !out_valid, "R1", $sformatf("after reset actual rdy=%0b vld=%0b expected 0/0", in_ready, out_valid));
    for (int i = 0; i < NB - 1; i++) step(1'b0, 1'b0, '0, 1'b0);
    chk(!in_ready, "R1", $sformatf("clear sweep actual rdy=%0b expected 0", in_ready));
    step(1'b0, 1'b0, '0, 1'b0);
    chk(in_ready, "R1", $sformatf("after sweep actual rdy=%0b expected 1", in_ready));

    // R2, R4: random codes, two orbits per period
    cur_req = "R4";
    run_orbits(6, 0, 100);
    flush();

    // R3: idle gaps between records and a mid-orbit resync
    cur_req = "R3";
    run_orbits(2, 40, 100);
    step(1'b1, 1'b0, rnd_codes(), 1'b1);
    run_orbits(4, 20, 100);
    flush();

    // R6: back-to-back hits on bucket 0 via repeated marker
    cur_req = "R6";
    for (int r = 0; r < 3; r++) step(1'b1, 1'b1, rnd_codes(), 1'b1);
    run_orbits(2, 0, 100);
    flush();

    // R2: all-dead and all-11 records in separate orbits
    cur_req = "R2";
    orbits_per_period = 16'd1;
    for (int b = 0; b < NB; b++) step(1'b1, b == 0, '0, 1'b1);
    for (int b = 0; b < NB; b++) step(1'b1, b == 0, {NCH{2'b11}}, 1'b1);
    for (int b = 0; b < NB; b++) step(1'b1, b == 0, {NCH{2'b01}}, 1'b1);
    flush();

    // R5: saturation with 48 hits per record over eight orbits
    cur_req = "R5";
    orbits_per_period = 16'd8;
    for (int o = 0; o < 8; o++)
      for (int b = 0; b < NB; b++) step(1'b1, b == 0, {NCH{2'b11}}, 1'b1);
    for (int r = 0; r < 7; r++) step(1'b1, 1'b1, {NCH{2'b10}}, 1'b1);
    flush();

    // R7: zero orbits acts as one
    cur_req = "R7";
    orbits_per_period = 16'd0;
    run_orbits(3, 10, 100);
    flush();

    // R9: random back-pressure on the readout
    cur_req = "R9";
    orbits_per_period = 16'd3;
    run_orbits(9, 10, 40);
    flush();

    // R10: readout stalled across period ends, switch deferred
    cur_req = "R10";
    orbits_per_period = 16'd1;
    run_orbits(5, 0, 0);
    run_orbits(4, 0, 100);
    flush();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule